// File: doc/BRIEF.md
# SM3 Compression Round Engine

This block runs the 64-round SM3 compression function over a 256-bit chaining value, one round per clock. An init pulse loads the starting chaining value from a 256-bit input. A start pulse copies the chaining value into eight 32-bit working registers (A to H, A taken from the most significant word). The engine then takes one message word pair per round, the expanded word and its primed partner, from an external expansion unit over a valid/ready handshake.

The 64th accepted pair ends the block. On that clock edge the working registers, after the final round, are XORed word by word into the chaining value. A one-cycle done pulse follows. The updated chaining value stays in place, so the next block only needs another start and another 64 word pairs. Padding, length encoding, byte loading and message expansion are left to the surrounding logic.

Round constants come from one register that rotates left by one bit per round. At the phase change the register is reloaded with the second base constant already rotated for that round, so no constant table is stored.

Top module: `sm3r_core`

## Requirements
- R1: While reset is held and after it is released, `done` and `w_ready` are low and `digest` is all zeros.
- R2: `init` while idle loads `iv` into the chaining value, which `digest` shows from the next cycle. `init` while a block is running has no effect. When `init` and `start` arrive together while idle, `init` is taken and `start` is dropped.
- R3: `start` while idle, with `init` low, begins a block. `w_ready` is high from the next cycle until the last word pair is accepted. `start` while a block is running has no effect.
- R4: A round is executed only on a clock edge where `w_valid` and `w_ready` are both high. In any other cycle the round position and the working registers hold.
- R5: Rounds 0 to 15 use x^y^z for both Boolean functions and the constant 0x79CC4519 rotated left by the round number. Rounds 16 to 63 use majority for the first function and choose (x&y)|(~x&z) for the second, with the constant 0x7A879D8A rotated left by (round mod 32).
- R6: Each round computes SS1 = rol7(rol12(A)+E+K) and SS2 = SS1^rol12(A). It then computes TT1 = FF(A,B,C)+D+SS2+W' and TT2 = GG(E,F,G)+H+SS1+W, all modulo 2^32. The registers are updated as A←TT1, B←A, C←rol9(B), D←C, E←P0(TT2), F←E, G←rol19(F), H←G, with P0(x) = x^rol9(x)^rol17(x). Here `w_word` is W and `w_prime` is W'.
- R7: On the edge that accepts the 64th pair, the chaining value becomes the old chaining value XOR the final working registers. `done` is high for exactly the next cycle, and `w_ready` is low in that cycle. `digest` carries h0 in bits 255:224 down to h7 in bits 31:0, and `iv` uses the same word order.
- R8: A later `start` without `init` compresses the next block on top of the chaining value left by the previous block.
- R9: With the standard SM3 initial value and the single padded block of "abc", `digest` equals 66c7f0f4 62eeedd9 d1f2d46b dc10e4e2 4167c487 5cf2f7a2 297da02b 8f4ba8e0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Load `iv` into the chaining value (idle only) |
| iv | input | 256 | Starting chaining value, h0 in the top word |
| start | input | 1 | Begin compressing one block (idle only) |
| w_valid | input | 1 | A word pair is offered |
| w_word | input | 32 | Expanded message word W for the current round |
| w_prime | input | 32 | Primed word W' for the current round |
| w_ready | output | 1 | Engine accepts a word pair this cycle |
| digest | output | 256 | Current chaining value |
| done | output | 1 | One-cycle pulse after a block completes |

## Verification
The known "abc" vector ties the whole round chain to a published result. All-zero and all-ones blocks stress the carry chains and both Boolean phases against an independent model. A block fed with regular gaps in `w_valid` must produce the same digest as an unbroken one, which separates a correctly stalled round counter from one that advances without a word pair. A chained two-block run and a block hit with stray `init` and `start` pulses in mid-flight show that the chaining value carries forward and cannot be disturbed while a block is running.

// File: rtl/sm3r_pkg.sv
package sm3r_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    // Working state, first member in the most significant word.
    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
        word_t f;
        word_t g;
        word_t h;
    } state_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    localparam word_t T_EARLY = 32'h79CC4519;
    localparam word_t T_LATE  = 32'h7A879D8A;

    function automatic word_t rol(input word_t x, input int unsigned n);
        int unsigned s;
        s = n % WORD_W;
        return (x << s) | (x >> (WORD_W - s));
    endfunction

    function automatic word_t perm0(input word_t x);
        return x ^ rol(x, 9) ^ rol(x, 17);
    endfunction

    function automatic word_t bool_ff(input word_t x, input word_t y,
                                      input word_t z, input logic late);
        return late ? (((x ^ y) & z) ^ (x & y)) : (x ^ y ^ z);
    endfunction

    function automatic word_t bool_gg(input word_t x, input word_t y,
                                      input word_t z, input logic late);
        return late ? ((x & y) | (~x & z)) : (x ^ y ^ z);
    endfunction

endpackage

// File: rtl/sm3r_round.sv
module sm3r_round
    import sm3r_pkg::*;
(
    input  state_t cur,
    input  word_t  msg_w,
    input  word_t  msg_wp,
    input  word_t  k_rot,
    input  logic   late,
    output state_t nxt
);
    word_t a12, ss1, ss2, tt1, tt2;

    always_comb begin
        a12   = rol(cur.a, 12);
        ss1   = rol(a12 + cur.e + k_rot, 7);
        ss2   = ss1 ^ a12;
        tt1   = bool_ff(cur.a, cur.b, cur.c, late) + cur.d + ss2 + msg_wp;
        tt2   = bool_gg(cur.e, cur.f, cur.g, late) + cur.h + ss1 + msg_w;
        nxt.a = tt1;
        nxt.b = cur.a;
        nxt.c = rol(cur.b, 9);
        nxt.d = cur.c;
        nxt.e = perm0(tt2);
        nxt.f = cur.e;
        nxt.g = rol(cur.f, 19);
        nxt.h = cur.g;
    end
endmodule

// File: rtl/sm3r_kgen.sv
module sm3r_kgen
    import sm3r_pkg::*;
#(
    parameter int SWITCH_RND = 16,
    parameter int RW         = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [RW-1:0] round_idx,
    output word_t         k_rot
);
    // Second base constant pre-rotated to its first round of use.
    localparam word_t K_RELOAD = rol(T_LATE, SWITCH_RND);

    word_t k_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            k_q <= T_EARLY;
        end else if (load) begin
            k_q <= T_EARLY;
        end else if (step) begin
            if (round_idx == RW'(SWITCH_RND - 1)) k_q <= K_RELOAD;
            else                                  k_q <= rol(k_q, 1);
        end
    end

    assign k_rot = k_q;
endmodule

// File: rtl/sm3r_ctrl.sv
module sm3r_ctrl
    import sm3r_pkg::*;
#(
    parameter int ROUNDS = 64,
    parameter int RW     = $clog2(ROUNDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          init,
    input  logic          start,
    input  logic          w_valid,
    output logic          busy,
    output logic          init_ok,
    output logic          start_ok,
    output logic          fire,
    output logic          last,
    output logic          done,
    output logic [RW-1:0] round_idx
);
    phase_e        phase_q;
    logic [RW-1:0] round_q;
    logic          done_q;

    assign busy     = (phase_q == PH_RUN);
    assign init_ok  = !busy && init;
    assign start_ok = !busy && start && !init;
    assign fire     = busy && w_valid;
    assign last     = (round_q == RW'(ROUNDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            round_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= fire && last;
            if (start_ok) begin
                phase_q <= PH_RUN;
                round_q <= '0;
            end else if (fire) begin
                if (last) begin
                    phase_q <= PH_IDLE;
                    round_q <= '0;
                end else begin
                    round_q <= round_q + 1'b1;
                end
            end
        end
    end

    assign done      = done_q;
    assign round_idx = round_q;
endmodule

// File: rtl/sm3r_core.sv
module sm3r_core
    import sm3r_pkg::*;
#(
    parameter int ROUNDS     = 64,
    parameter int SWITCH_RND = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         init,
    input  logic [255:0] iv,
    input  logic         start,
    input  logic         w_valid,
    input  logic [31:0]  w_word,
    input  logic [31:0]  w_prime,
    output logic         w_ready,
    output logic [255:0] digest,
    output logic         done
);
    localparam int RW = $clog2(ROUNDS);

    logic          busy, init_ok, start_ok, fire, last, late;
    logic [RW-1:0] round_q;
    word_t         k_rot;
    state_t        chain_q, work_q, work_nxt;

    sm3r_ctrl #(.ROUNDS(ROUNDS), .RW(RW)) u_ctrl (
        .clk(clk), .rst(rst), .init(init), .start(start), .w_valid(w_valid),
        .busy(busy), .init_ok(init_ok), .start_ok(start_ok), .fire(fire),
        .last(last), .done(done), .round_idx(round_q)
    );

    sm3r_kgen #(.SWITCH_RND(SWITCH_RND), .RW(RW)) u_kgen (
        .clk(clk), .rst(rst), .load(start_ok), .step(fire),
        .round_idx(round_q), .k_rot(k_rot)
    );

    assign late = (round_q >= RW'(SWITCH_RND));

    sm3r_round u_round (
        .cur(work_q), .msg_w(w_word), .msg_wp(w_prime),
        .k_rot(k_rot), .late(late), .nxt(work_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            work_q  <= '0;
        end else begin
            if (init_ok) chain_q <= iv;
            if (start_ok) begin
                work_q <= chain_q;
            end else if (fire) begin
                work_q <= work_nxt;
                if (last) chain_q <= chain_q ^ work_nxt;
            end
        end
    end

    assign w_ready = busy;
    assign digest  = chain_q;
endmodule

// File: rtl/sm3r_checker.sv
module sm3r_checker #(
    parameter int RW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          init,
    input logic [255:0]  iv,
    input logic          start,
    input logic          w_valid,
    input logic          w_ready,
    input logic [255:0]  digest,
    input logic          done,
    input logic [RW-1:0] round_idx
);
    // R2: idle init lands on the digest one cycle later
    a_r2_init_loads: assert property (@(posedge clk) disable iff (rst)
        (init && !w_ready) |=> (digest == $past(iv)));

    // R3: idle start without init opens the handshake
    a_r3_start_opens: assert property (@(posedge clk) disable iff (rst)
        (start && !init && !w_ready) |=> w_ready);

    // R4: no valid word pair, no progress
    a_r4_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (w_ready && !w_valid) |=> (w_ready && round_idx == $past(round_idx)));

    // R7: done is a single-cycle pulse outside the running phase
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !w_ready);

    // R7: chaining value moves only at block completion
    a_r7_digest_steady: assert property (@(posedge clk) disable iff (rst)
        w_ready |=> ($stable(digest) || done));
endmodule

bind sm3r_core sm3r_checker #(.RW(RW)) u_sm3r_checker (
    .clk(clk), .rst(rst), .init(init), .iv(iv), .start(start),
    .w_valid(w_valid), .w_ready(w_ready), .digest(digest), .done(done),
    .round_idx(round_q)
);

// File: tb/test_sm3r_core.sv
module test_sm3r_core;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         init = 1'b0;
    logic [255:0] iv = '0;
    logic         start = 1'b0;
    logic         w_valid = 1'b0;
    logic [31:0]  w_word = '0;
    logic [31:0]  w_prime = '0;
    logic         w_ready;
    logic [255:0] digest;
    logic         done;

    int tests = 0;
    int fails = 0;

    localparam logic [255:0] STD_IV =
        256'h7380166f_4914b2b9_172442d7_da8a0600_a96f30bc_163138aa_e38dee4d_b0fb0e4e;
    localparam logic [255:0] ABC_DIGEST =
        256'h66c7f0f4_62eeedd9_d1f2d46b_dc10e4e2_4167c487_5cf2f7a2_297da02b_8f4ba8e0;
    localparam logic [511:0] ABC_BLOCK = {32'h61626380, 448'h0, 32'h00000018};

    logic [31:0] mw [68];
    logic [31:0] mwp[64];

    sm3r_core i_sm3r_core (
        .clk(clk), .rst(rst), .init(init), .iv(iv), .start(start),
        .w_valid(w_valid), .w_word(w_word), .w_prime(w_prime),
        .w_ready(w_ready), .digest(digest), .done(done)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] brol(input logic [31:0] x, input int n);
        int s;
        s = n % 32;
        if (s == 0) return x;
        return (x << s) | (x >> (32 - s));
    endfunction

    task automatic fill_words(input logic [511:0] blk);
        for (int i = 0; i < 16; i++) mw[i] = blk[511 - 32*i -: 32];
        for (int i = 16; i < 68; i++) begin
            logic [31:0] t;
            t = mw[i-16] ^ mw[i-9] ^ brol(mw[i-3], 15);
            mw[i] = t ^ brol(t, 15) ^ brol(t, 23) ^ brol(mw[i-13], 7) ^ mw[i-6];
        end
        for (int i = 0; i < 64; i++) mwp[i] = mw[i] ^ mw[i+4];
    endtask

    // Independent compression model over the words in mw/mwp.
    function automatic logic [255:0] ref_compress(input logic [255:0] v);
        logic [31:0] ra, rb, rc, rd, re, rf, rg, rh, k, s1, s2, f1, g1, t1, t2;
        {ra, rb, rc, rd, re, rf, rg, rh} = v;
        for (int j = 0; j < 64; j++) begin
            k  = brol((j < 16) ? 32'h79CC4519 : 32'h7A879D8A, j);
            s1 = brol(brol(ra, 12) + re + k, 7);
            s2 = s1 ^ brol(ra, 12);
            f1 = (j < 16) ? (ra ^ rb ^ rc) : ((ra & rb) | (ra & rc) | (rb & rc));
            g1 = (j < 16) ? (re ^ rf ^ rg) : ((re & rf) | (~re & rg));
            t1 = f1 + rd + s2 + mwp[j];
            t2 = g1 + rh + s1 + mw[j];
            rd = rc; rc = brol(rb, 9); rb = ra; ra = t1;
            rh = rg; rg = brol(rf, 19); rf = re;
            re = t2 ^ brol(t2, 9) ^ brol(t2, 17);
        end
        return {ra, rb, rc, rd, re, rf, rg, rh} ^ v;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [255:0] act, input logic [255:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Load a chaining value while idle (R2).
    task automatic do_init(input logic [255:0] v);
        @(negedge clk);
        init = 1'b1; iv = v;
        @(negedge clk);
        init = 1'b0;
    endtask

    // Compress one block. gap>0 drops w_valid before every gap-th word;
    // inject fires stray init/start pulses during the gaps.
    task automatic run_block(input logic [511:0] blk, input int gap,
                             input bit inject, output logic [255:0] dig);
        fill_words(blk);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(w_ready === 1'b1, "R3 ready after start", {255'h0, w_ready}, 256'h1);
        for (int j = 0; j < 64; j++) begin
            if (gap > 0 && (j % gap) == 1) begin
                w_valid = 1'b0;
                if (inject) begin
                    init = 1'b1; iv = ~STD_IV; start = 1'b1;
                end
                @(negedge clk);
                init = 1'b0; start = 1'b0;
                if (j == 1)
                    chk(w_ready === 1'b1, "R4 ready held in stall",
                        {255'h0, w_ready}, 256'h1);
            end
            w_valid = 1'b1; w_word = mw[j]; w_prime = mwp[j];
            @(negedge clk);
            if (j == 62)
                chk(done === 1'b0, "R7 no done before last round",
                    {255'h0, done}, 256'h0);
        end
        w_valid = 1'b0;
        chk(done === 1'b1, "R7 done after last pair", {255'h0, done}, 256'h1);
        chk(w_ready === 1'b0, "R7 ready low with done", {255'h0, w_ready}, 256'h0);
        dig = digest;
        @(negedge clk);
        chk(done === 1'b0, "R7 done lasts one cycle", {255'h0, done}, 256'h0);
    endtask

    task automatic t_reset;
        chk(done === 1'b0 && w_ready === 1'b0, "R1 controls low after reset",
            {254'h0, done, w_ready}, 256'h0);
        chk(digest === 256'h0, "R1 digest zero after reset", digest, 256'h0);
    endtask

    task automatic t_init;
        do_init(STD_IV);
        chk(digest === STD_IV, "R2 init loads iv", digest, STD_IV);
        // init and start together: init wins, no block begins
        @(negedge clk);
        init = 1'b1; start = 1'b1; iv = 256'h1234;
        @(negedge clk);
        init = 1'b0; start = 1'b0;
        chk(digest === 256'h1234, "R2 init over start", digest, 256'h1234);
        chk(w_ready === 1'b0, "R2 start dropped with init", {255'h0, w_ready}, 256'h0);
    endtask

    task automatic t_abc;
        logic [255:0] d;
        do_init(STD_IV);
        fill_words(ABC_BLOCK);
        chk(ref_compress(STD_IV) === ABC_DIGEST, "R9 bench model sanity",
            ref_compress(STD_IV), ABC_DIGEST);
        run_block(ABC_BLOCK, 0, 1'b0, d);
        chk(d === ABC_DIGEST, "R9 abc digest (R5 R6 R7)", d, ABC_DIGEST);
    endtask

    task automatic t_patterns;
        logic [255:0] d, e;
        do_init(STD_IV);
        fill_words('0);
        e = ref_compress(STD_IV);
        run_block('0, 0, 1'b0, d);
        chk(d === e, "R5 R6 all-zero block", d, e);
        do_init(256'h0);
        fill_words({512{1'b1}});
        e = ref_compress(256'h0);
        run_block({512{1'b1}}, 0, 1'b0, d);
        chk(d === e, "R5 R6 all-ones block from zero iv", d, e);
    endtask

    task automatic t_stall;
        logic [255:0] d;
        do_init(STD_IV);
        run_block(ABC_BLOCK, 3, 1'b0, d);
        chk(d === ABC_DIGEST, "R4 gapped handshake same digest", d, ABC_DIGEST);
    endtask

    task automatic t_chain;
        logic [255:0] d, e;
        logic [511:0] b2;
        b2 = {16{32'hA5C3_0F96}};
        do_init(STD_IV);
        run_block(ABC_BLOCK, 0, 1'b0, d);
        fill_words(b2);
        e = ref_compress(ABC_DIGEST);
        run_block(b2, 0, 1'b0, d);
        chk(d === e, "R8 second block chains", d, e);
    endtask

    task automatic t_ignore;
        logic [255:0] d;
        do_init(STD_IV);
        run_block(ABC_BLOCK, 7, 1'b1, d);
        chk(d === ABC_DIGEST, "R3 R2 stray start/init while busy ignored",
            d, ABC_DIGEST);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_init();
        t_abc();
        t_patterns();
        t_stall();
        t_chain();
        t_ignore();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule